// File: doc/BRIEF.md
# I2C Target Controller with Clock-Stretch Release

This block is the target side of a two-wire I2C bus. It watches both lines through a short synchroniser and detects start and stop conditions. It keeps a bus-busy flag. It collects the address byte and answers either its programmed 7-bit address or the all-zero general-call byte. Once addressed, it moves data bytes in or out. Both lines are treated as open-drain: the block only ever asks for a line to be pulled low.

Each acknowledged byte ends with a one-cycle interrupt pulse, and the release flag clears at the same time. While that flag is zero, the block holds SCL low and the bus master must wait. Software frees the bus in one of three ways: it reads the data register, it writes the data register, or it writes a one into bit 0 of the control register. SCL comes free a fixed number of clocks after the flag returns to one. The interface has two registers, chosen by a select input: select 0 is the data register, select 1 is the control and status register.

The byte engine has eight states:
- IDLE: the bus is free or unused.
- ADDR: the address byte is shifting in.
- ADDR_ACK: the block drives the address acknowledge.
- RX: a write byte is shifting in.
- RX_ACK: the block drives the data acknowledge.
- TX: a read byte is shifting out.
- TX_ACK: the block samples the master's acknowledge.
- SKIP: the block stays silent until the next start or stop.

The transitions are:
- start → ADDR from any state; stop → IDLE from any state.
- ADDR → ADDR_ACK on a match, or ADDR → SKIP on a mismatch, at the falling SCL edge after the eighth bit.
- ADDR_ACK → RX or TX, chosen by the direction bit, at the end of the acknowledge clock.
- RX → RX_ACK after eight bits; RX_ACK → RX at the end of the acknowledge clock.
- TX → TX_ACK after eight bits.
- TX_ACK → TX when the master acknowledges, or TX_ACK → SKIP when it does not.

Top module: `i2c_target_ctrl`

## Requirements
- R1: `bus_busy` becomes 1 after a start condition (SDA falling while SCL is high) and returns to 0 after a stop condition (SDA rising while SCL is high).
- R2: When the first byte after a start carries the own address in bits 7..1, the block pulls SDA low during the ninth clock. It raises `irq` for exactly one clock cycle when that ninth SCL clock falls.
- R3: A first byte of 0x00 (general call) is acknowledged in the same way and raises `irq`. Status bit 2 then reads 1 until the next start.
- R4: After an accepted write address or general call, every further byte is acknowledged and stored in the data register, and `irq` pulses once per byte.
- R5: An address byte that is neither the own address nor 0x00 gets no acknowledge and no `irq`. The block then drives neither line until the next start or stop.
- R6: Each `irq` pulse clears the release flag (status bit 0). While that flag is 0, `scl_pull_low` is 1.
- R7: The release flag becomes 1 on a read of the data register, on a write of the data register, or on a control write with bit 0 = 1. A control write with bit 0 = 0, and a status read, leave it unchanged.
- R8: After the release flag turns to 1, `scl_pull_low` stays 1 for REL_DELAY more clocks and then drops.
- R9: With the direction bit set to 1, status bit 3 reads 1. The data register is sent MSB first, and a master acknowledge on the ninth clock raises `irq`.
- R10: A master not-acknowledge after a read byte raises no `irq` and leaves SDA free until the next start or stop.
- R11: A repeated start in any state restarts address reception.
- R12: After reset both pull-low outputs are 0, `irq` and `bus_busy` are 0, and the release flag is 1 (status read: bit 0 release flag, bit 1 bus busy, bit 2 general call, bit 3 read direction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_low | output | 1 | Pull SCL low when 1 |
| sda_pull_low | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Programmed target address |
| reg_sel | input | 1 | 0 = data register, 1 = control/status |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | One-cycle pulse after each acknowledged byte |
| bus_busy | output | 1 | Bus busy flag |

## Verification
The assertions rely on two properties of the bus. First, SDA changes only while SCL is low, except when it forms a start or stop. Second, each line level lasts longer than the synchroniser depth plus one clock, so that start, stop and clock edges come out of the synchroniser as separate events. The bench master respects both. It holds each SCL phase for 20 clocks, it moves SDA only some clocks after SCL has fallen, and it waits on the wired line level so that every stretch the block applies is honoured. Register strobes last one cycle and change on the falling clock edge.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_line_sync.sv
`timescale 1ns/1ps
module i2c_tgt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_line,
    input  logic sda_line,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prev;

    assign raw = {scl_line, sda_line};

    // one synchroniser chain per line; idle level of both lines is high
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    assign sda_s     = lvl[0];
    assign scl_rise  = lvl[1] & ~prev[1];
    assign scl_fall  = ~lvl[1] & prev[1];
    assign start_det = lvl[1] & prev[1] & prev[0] & ~lvl[0];
    assign stop_det  = lvl[1] & prev[1] & ~prev[0] & lvl[0];
endmodule

// File: rtl/i2c_tgt_release.sv
`timescale 1ns/1ps
module i2c_tgt_release #(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic sw_set,
    output logic rel_flag,
    output logic scl_hold
);
    localparam int DW = $clog2(DELAY + 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_flag <= 1'b1;
            cnt      <= '0;
        end else if (irq) begin
            rel_flag <= 1'b0;
            cnt      <= '0;
        end else if (sw_set && !rel_flag) begin
            rel_flag <= 1'b1;
            cnt      <= DW'(DELAY);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign scl_hold = !rel_flag || (cnt != '0);

    AST_IRQ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !rel_flag); // R6
    AST_NO_SELF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rel_flag && !sw_set) |=> !rel_flag); // R7
    AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_flag) |-> scl_hold); // R8
endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              dat_we,
    input  logic [BYTE_W-1:0] dat_wdata,
    output logic              sda_low,
    output logic              irq,
    output logic              bus_busy,
    output logic              gc_hit,
    output logic              rd_dir,
    output logic [BYTE_W-1:0] data_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              full;
    logic              ack_seen;
    logic              addr_hit;

    assign addr_hit = (shreg[BYTE_W-1:1] == own_addr) || (shreg == '0);

    // next-state
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (scl_fall && full) state_n = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_n = rd_dir ? ST_TX : ST_RX;
                ST_RX:       if (scl_fall && full) state_n = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_n = ST_RX;
                ST_TX:       if (scl_fall && cnt == LAST) state_n = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_n = ack_seen ? ST_TX : ST_SKIP;
                ST_SKIP:     state_n = ST_SKIP;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            full     <= 1'b0;
            ack_seen <= 1'b0;
            bus_busy <= 1'b0;
            gc_hit   <= 1'b0;
            rd_dir   <= 1'b0;
            data_q   <= '0;
        end else begin
            state <= state_n;
            if (start_det)     bus_busy <= 1'b1;
            else if (stop_det) bus_busy <= 1'b0;
            if (dat_we) data_q <= dat_wdata;
            if (start_det || stop_det) begin
                cnt  <= '0;
                full <= 1'b0;
                if (start_det) gc_hit <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_ADDR && addr_hit) begin
                                gc_hit <= (shreg == '0);
                                rd_dir <= shreg[0];
                            end
                        end
                    end
                    ST_RX_ACK: if (scl_fall) data_q <= shreg;
                    ST_TX:     if (scl_fall) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                    ST_TX_ACK: if (scl_rise) ack_seen <= !sda_s;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_low = 1'b0;
        irq     = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_RX_ACK: begin
                sda_low = 1'b1;
                irq     = scl_fall;
            end
            ST_TX:     sda_low = !data_q[LAST - cnt];
            ST_TX_ACK: irq = scl_fall && ack_seen;
            default: ;
        endcase
    end

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> (state == ST_SKIP) || $past(start_det) || $past(stop_det)); // R5
endmodule

// File: rtl/i2c_target_ctrl.sv
`timescale 1ns/1ps
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REL_DELAY   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              bus_busy
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              rel_flag, gc_hit, rd_dir, sw_set, dat_we;
    logic [BYTE_W-1:0] data_q;

    assign dat_we = reg_wr && !reg_sel;
    assign sw_set = (!reg_sel && (reg_wr || reg_rd)) || (reg_sel && reg_wr && reg_wdata[0]);

    i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_line(scl_i), .sda_line(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .dat_we(dat_we), .dat_wdata(reg_wdata),
        .sda_low(sda_pull_low), .irq(irq), .bus_busy(bus_busy),
        .gc_hit(gc_hit), .rd_dir(rd_dir), .data_q(data_q)
    );

    i2c_tgt_release #(.DELAY(REL_DELAY)) u_rel (
        .clk(clk), .rst_n(rst_n), .irq(irq), .sw_set(sw_set),
        .rel_flag(rel_flag), .scl_hold(scl_pull_low)
    );

    assign reg_rdata = reg_sel ? {4'b0, rd_dir, gc_hit, bus_busy, rel_flag} : data_q;

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy); // R1
    AST_FREE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy); // R1
    AST_IRQ_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> scl_fall); // R2
endmodule

// File: tb/sim_i2c_target_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_target_ctrl;
    localparam int HALF  = 20;
    localparam int REL_D = 4;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_pull_low, sda_pull_low, irq, bus_busy;
    logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    wire scl_line = m_scl & ~scl_pull_low;
    wire sda_line = m_sda & ~sda_pull_low;

    int checks = 0, fails = 0, irq_cnt = 0;

    always #2.5 clk = ~clk;

    i2c_target_ctrl #(.SYNC_STAGES(2), .REL_DELAY(REL_D)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
        .own_addr(OWN), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .bus_busy(bus_busy)
    );

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        m_sda = b;
        wt(HALF);
        m_scl = 1'b1;
        wait_scl_high();
        wt(HALF / 2);
        seen = sda_line;
        wt(HALF / 2);
        m_scl = 1'b0;
        wt(4);
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        wt(HALF);
        m_scl = 1'b1;
        wait_scl_high();
        wt(HALF);
        m_sda = 1'b0;
        wt(HALF);
        m_scl = 1'b0;
        wt(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        wt(HALF);
        m_scl = 1'b1;
        wait_scl_high();
        wt(HALF);
        m_sda = 1'b1;
        wt(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, ack_n);
        m_sda = 1'b1;
        wt(HALF);
    endtask

    task automatic read_byte(input logic m_ack_n, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(m_ack_n, s);
        m_sda = 1'b1;
        wt(HALF);
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic t_reset();
        logic [7:0] st;
        chk("R12 scl_pull_low", int'(scl_pull_low), 0);
        chk("R12 sda_pull_low", int'(sda_pull_low), 0);
        chk("R12 irq", int'(irq), 0);
        reg_read(1'b1, st);
        chk("R12 status", int'(st), 1);
    endtask

    task automatic t_write_own();
        logic a;
        logic [7:0] st, d;
        int n0;
        bus_start();
        chk("R1 busy after start", int'(bus_busy), 1);
        n0 = irq_cnt;
        send_byte({OWN, 1'b0}, a);
        chk("R2 address ack", int'(a), 0);
        chk("R2 one irq", irq_cnt - n0, 1);
        chk("R6 scl held", int'(scl_pull_low), 1);
        reg_write(1'b1, 8'h00);
        reg_read(1'b1, st);
        chk("R7 zero write keeps flag", int'(st[0]), 0);
        chk("R6 still held", int'(scl_pull_low), 1);
        // R8 timing of release
        @(negedge clk);
        reg_sel = 1'b1; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 held at set", int'(scl_pull_low), 1);
        wt(REL_D - 1);
        chk("R8 held before delay", int'(scl_pull_low), 1);
        wt(1);
        chk("R8 released after delay", int'(scl_pull_low), 0);
        n0 = irq_cnt;
        send_byte(8'hC3, a);
        chk("R4 data ack", int'(a), 0);
        chk("R4 data irq", irq_cnt - n0, 1);
        reg_read(1'b0, d);
        chk("R4 data stored", int'(d), 8'hC3);
        reg_read(1'b1, st);
        chk("R7 data read sets flag", int'(st[0]), 1);
        wt(REL_D + 2);
        bus_stop();
        chk("R1 free after stop", int'(bus_busy), 0);
    endtask

    task automatic t_general_call();
        logic a;
        logic [7:0] st, d;
        int n0;
        bus_start();
        n0 = irq_cnt;
        send_byte(8'h00, a);
        chk("R3 gc ack", int'(a), 0);
        chk("R3 gc irq", irq_cnt - n0, 1);
        reg_read(1'b1, st);
        chk("R3 gc status", int'(st[2]), 1);
        reg_write(1'b0, 8'h11);
        reg_read(1'b1, st);
        chk("R7 data write sets flag", int'(st[0]), 1);
        wt(REL_D + 2);
        n0 = irq_cnt;
        send_byte(8'h3C, a);
        chk("R4 gc data ack", int'(a), 0);
        chk("R4 gc data irq", irq_cnt - n0, 1);
        reg_read(1'b0, d);
        chk("R4 gc data stored", int'(d), 8'h3C);
        wt(REL_D + 2);
        bus_stop();
    endtask

    task automatic t_mismatch_restart();
        logic a;
        int n0;
        bus_start();
        n0 = irq_cnt;
        send_byte({7'h33, 1'b0}, a);
        chk("R5 no ack", int'(a), 1);
        chk("R5 no irq", irq_cnt - n0, 0);
        chk("R5 scl free", int'(scl_pull_low), 0);
        send_byte(8'h00, a);
        chk("R5 ignored byte", int'(a), 1);
        chk("R5 sda free", int'(sda_pull_low), 0);
        bus_start();
        n0 = irq_cnt;
        send_byte({OWN, 1'b0}, a);
        chk("R11 restart ack", int'(a), 0);
        chk("R11 restart irq", irq_cnt - n0, 1);
        reg_write(1'b1, 8'h01);
        wt(REL_D + 2);
        bus_stop();
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] st, v;
        int n0;
        bus_start();
        send_byte({OWN, 1'b1}, a);
        chk("R9 read address ack", int'(a), 0);
        reg_read(1'b1, st);
        chk("R9 direction status", int'(st[3]), 1);
        reg_write(1'b0, 8'hA5);
        wt(REL_D + 2);
        n0 = irq_cnt;
        read_byte(1'b0, v);
        chk("R9 first byte", int'(v), 8'hA5);
        chk("R9 irq after master ack", irq_cnt - n0, 1);
        reg_write(1'b0, 8'h5C);
        wt(REL_D + 2);
        n0 = irq_cnt;
        read_byte(1'b1, v);
        chk("R9 second byte", int'(v), 8'h5C);
        chk("R10 no irq on nack", irq_cnt - n0, 0);
        chk("R10 sda free", int'(sda_pull_low), 0);
        chk("R10 scl free", int'(scl_pull_low), 0);
        bus_stop();
        chk("R1 free after read", int'(bus_busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_write_own();
        t_general_call();
        t_mismatch_restart();
        t_read();
        wt(10);
        summary();
        $finish;
    end
endmodule